// File: doc/BRIEF.md
# Overcurrent Fault Latch Controller

This block sits between a gate-drive command path and a shared enable/fault pin. It filters the digital output of an overcurrent comparator so that only a sustained trip is taken as real. A confirmed trip is stored in a latch in which setting wins over clearing. While the latch is in its minimum hold window, the block pulls the shared open-drain pin low. While the latch is set at all, both gate outputs are forced off.

The same pin serves as an enable input. Its sampled level passes through a fixed delay line and blanks the gate outputs whenever it reads low. The latch clears only after two things have happened: the hold window has expired, and the delayed pin level has been seen high again, whether raised by the external pull-up or by the controller. Undervoltage flags from the low-side and bootstrap supplies also pull the pin low, but they are not latched.

The pin itself, its pull-up and the analog comparator are outside the block. The pin level arrives here as a digital sample, and the pull-down arrives as an enable.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `pin_pull_o` is 0 and both gate outputs are 0. An assertion of reset in mid-run clears a latched fault at once.
- R2: A comparator input that stays high for fewer than FILT_CYCLES consecutive clock edges (default 8) produces no fault: `pin_pull_o` stays 0 and the gates keep following their commands.
- R3: Each low sample of the comparator input restarts the filter count. Two pulses of 7 cycles each, separated by one low cycle, do not add up to a trip.
- R4: When the comparator has been high for FILT_CYCLES edges, `pin_pull_o` rises on the next edge, that is FILT_CYCLES+1 edges after the first high sample. From that edge on, both gate outputs are 0.
- R5: Setting has priority over clearing. If a confirmed trip and a high delayed pin level reach the latch in the same cycle after the hold window, the latch returns straight to its hold window with no released cycle.
- R6: If the comparator is still confirmed when the hold window ends, the hold window restarts, and `pin_pull_o` stays high without a gap.
- R7: After a trip, `pin_pull_o` stays high for exactly HOLD_CYCLES cycles (default 32), whatever the comparator and pin do during that time. It then drops.
- R8: Once the hold window has ended, the gates stay off for as long as the pin is held low. They return exactly PIN_DLY+1 edges (default 3+1) after the pin is first sampled high.
- R9: Either undervoltage flag drives `pin_pull_o` high in the same cycle and turns the gates off through the pin path. When the flag goes away, the pull-down is released and the gates resume without any latched fault.
- R10: A low pin level turns both gate outputs off exactly PIN_DLY edges after it is first sampled. A high level enables them after the same delay.
- R11: When no fault is latched and the delayed pin level is high, each gate output equals its command input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oc_cmp_i | input | 1 | Digital overcurrent comparator output, high means overcurrent |
| pin_lvl_i | input | 1 | Sampled logic level of the shared enable/fault pin |
| uv_vdd_i | input | 1 | Low-side supply undervoltage flag |
| uv_boot_i | input | 1 | High-side (bootstrap) supply undervoltage flag |
| gate_hi_i | input | 1 | High-side gate command |
| gate_lo_i | input | 1 | Low-side gate command |
| pin_pull_o | output | 1 | Enable for the open-drain pull-down on the shared pin |
| gate_hi_o | output | 1 | Gated high-side drive |
| gate_lo_o | output | 1 | Gated low-side drive |

## Verification
A filter counter that fails to restart shows up as a `pin_pull_o` rise after short, separated pulses. A counter that is off by one moves the rise one edge away from FILT_CYCLES+1. A hold counter of the wrong length shows as the pull-down dropping one cycle early or late. A latch without set priority, or without re-arming, shows as a single cycle in which `pin_pull_o` is low at the exact edge where the hold expires or where pin and trip coincide. A latch that clears without regard to the pin returns the gates one edge before PIN_DLY+1. Each of these is therefore visible at the ports in a precise cycle, and the checks sample exactly there.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // Latch states: clear, inside the minimum hold window, waiting for the pin to read high
  typedef enum logic [1:0] {
    LT_IDLE = 2'd0,
    LT_HOLD = 2'd1,
    LT_WAIT = 2'd2
  } latch_st_e;

  // Counter width for a count range 0..n-1, never below one bit
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync #(
  parameter int unsigned STAGES = 2  // must be 2 or more
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ocp_trip_filter.sv
module ocp_trip_filter #(
  parameter int unsigned FILT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  output logic trip_o
);

  localparam int unsigned          CW   = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0]        CMAX = CW'(FILT_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Saturating run-length counter, restarted by any low sample
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!oc_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != CMAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign trip_o = (cnt_q == CMAX);

  // R2
  trip_needs_oc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(oc_i));

  // R3
  low_sample_drops_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_i |=> !trip_o);

endmodule

// File: rtl/ocp_pin_delay.sv
module ocp_pin_delay #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        stg_d = pin_i;
      end
    end else begin : g_chain
      always_comb begin
        stg_d = {stg_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  // Reset to "pin low" so the gates start disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign pin_o = stg_q[STAGES-1];

endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch
  import ocp_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 32  // must be 2 or more
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic pin_hi_i,
  output logic fault_o,
  output logic hold_o
);

  localparam int unsigned   HW    = cnt_w(HOLD_CYCLES);
  localparam logic [HW-1:0] HLAST = HW'(HOLD_CYCLES - 1);

  latch_st_e     state_q;
  latch_st_e     state_d;
  logic [HW-1:0] hold_q;
  logic [HW-1:0] hold_d;
  logic          hold_en;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    unique case (state_q)
      LT_IDLE: begin
        if (trip_i) begin
          state_d = LT_HOLD;
          hold_d  = '0;
          hold_en = 1'b1;
        end
      end
      LT_HOLD: begin
        hold_en = 1'b1;
        if (hold_q == HLAST) begin
          hold_d  = '0;
          state_d = trip_i ? LT_HOLD : LT_WAIT;  // re-arm while still tripped
        end else begin
          hold_d  = hold_q + 1'b1;
        end
      end
      LT_WAIT: begin
        if (trip_i) begin                         // set wins over clear
          state_d = LT_HOLD;
          hold_d  = '0;
          hold_en = 1'b1;
        end else if (pin_hi_i) begin
          state_d = LT_IDLE;
        end
      end
      default: begin
        state_d = LT_IDLE;
        hold_d  = '0;
        hold_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LT_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign fault_o = (state_q != LT_IDLE);
  assign hold_o  = (state_q == LT_HOLD);

  // R4
  fault_set_by_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(trip_i));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LT_WAIT && trip_i) |=> (state_q == LT_HOLD));

  // R7
  hold_full_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == LT_WAIT) |-> ($past(hold_q) == HLAST));

  // R8
  clear_needs_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> ($past(pin_hi_i) && !$past(trip_i)));

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl #(
  parameter int unsigned FILT_CYCLES = 8,
  parameter int unsigned HOLD_CYCLES = 32,
  parameter int unsigned PIN_DLY     = 3,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_cmp_i,
  input  logic pin_lvl_i,
  input  logic uv_vdd_i,
  input  logic uv_boot_i,
  input  logic gate_hi_i,
  input  logic gate_lo_i,
  output logic pin_pull_o,
  output logic gate_hi_o,
  output logic gate_lo_o
);

  logic rst_n_s;
  logic trip;
  logic pin_hi_dly;
  logic fault;
  logic hold;
  logic uv_any;
  logic gate_off;

  ocp_rst_sync #(
    .STAGES (RST_STAGES)
  ) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  ocp_trip_filter #(
    .FILT_CYCLES (FILT_CYCLES)
  ) i_trip_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .oc_i   (oc_cmp_i),
    .trip_o (trip)
  );

  ocp_pin_delay #(
    .STAGES (PIN_DLY)
  ) i_pin_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .pin_i  (pin_lvl_i),
    .pin_o  (pin_hi_dly)
  );

  ocp_fault_latch #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) i_fault_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .trip_i   (trip),
    .pin_hi_i (pin_hi_dly),
    .fault_o  (fault),
    .hold_o   (hold)
  );

  always_comb begin
    uv_any     = uv_vdd_i | uv_boot_i;
    pin_pull_o = hold | uv_any;
    gate_off   = fault | ~pin_hi_dly;
    gate_hi_o  = gate_hi_i & ~gate_off;
    gate_lo_o  = gate_lo_i & ~gate_off;
  end

endmodule

// File: tb/test_ocp_fault_ctrl.sv
`timescale 1ns/1ps
module test_ocp_fault_ctrl;

  localparam int unsigned FILT = 8;
  localparam int unsigned HOLD = 32;
  localparam int unsigned PDLY = 3;
  localparam int unsigned NROW = 12;

  // Row layout: [20:17] requirement, [16] oc, [15] ext_low, [14] uv_vdd,
  // [13] uv_boot, [12] gate_hi cmd, [11] gate_lo cmd, [10:3] cycles,
  // [2] expected pull, [1] expected gate_hi, [0] expected gate_lo
  localparam logic [20:0] VEC [NROW] = '{
    {4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd10, 1'b0, 1'b1, 1'b0}, // R11
    {4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 1'b0, 1'b1}, // R11
    {4'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd6,  1'b0, 1'b0, 1'b0}, // R10
    {4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd6,  1'b0, 1'b1, 1'b1}, // R10
    {4'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5,  1'b1, 1'b0, 1'b0}, // R9
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd8,  1'b0, 1'b1, 1'b1}, // R9
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd5,  1'b1, 1'b0, 1'b0}, // R9
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd8,  1'b0, 1'b1, 1'b1}, // R9
    {4'd2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd7,  1'b0, 1'b1, 1'b1}, // R2
    {4'd3,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 1'b1, 1'b1}, // R3
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd7,  1'b0, 1'b1, 1'b1}, // R3
    {4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd4,  1'b0, 1'b1, 1'b1}  // R2
  };

  logic clk = 1'b0;
  logic rst_n;
  logic oc, ext_low, uv_vdd, uv_boot, ghi, glo;
  logic pin_lvl;
  logic pull, gate_hi, gate_lo;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  assign pin_lvl = ~(pull | ext_low);

  ocp_fault_ctrl #(
    .FILT_CYCLES (FILT),
    .HOLD_CYCLES (HOLD),
    .PIN_DLY     (PDLY),
    .RST_STAGES  (2)
  ) i_ocp_fault_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .oc_cmp_i   (oc),
    .pin_lvl_i  (pin_lvl),
    .uv_vdd_i   (uv_vdd),
    .uv_boot_i  (uv_boot),
    .gate_hi_i  (ghi),
    .gate_lo_i  (glo),
    .pin_pull_o (pull),
    .gate_hi_o  (gate_hi),
    .gate_lo_o  (gate_lo)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic step(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; oc = 1'b0; ext_low = 1'b0; uv_vdd = 1'b0; uv_boot = 1'b0;
    ghi = 1'b1; glo = 1'b1;
    step(3);
    chk(pull, 1'b0, "R1 pull in reset");
    chk(gate_hi, 1'b0, "R1 gate_hi in reset");
    chk(gate_lo, 1'b0, "R1 gate_lo in reset");
    rst_n = 1'b1;
    step(1);
    chk(gate_hi, 1'b0, "R1 gate_hi just after reset");
    step(2 + PDLY + 3);

    // Vector table
    for (int r = 0; r < NROW; r++) begin
      logic [20:0] v;
      v = VEC[r];
      oc = v[16]; ext_low = v[15]; uv_vdd = v[14]; uv_boot = v[13];
      ghi = v[12]; glo = v[11];
      step(int'(v[10:3]));
      chk(pull,    v[2], $sformatf("row %0d R%0d pull", r, v[20:17]));
      chk(gate_hi, v[1], $sformatf("row %0d R%0d gate_hi", r, v[20:17]));
      chk(gate_lo, v[0], $sformatf("row %0d R%0d gate_lo", r, v[20:17]));
    end
    oc = 1'b0; ext_low = 1'b0; uv_vdd = 1'b0; uv_boot = 1'b0; ghi = 1'b1; glo = 1'b1;
    step(4);

    // R10 exact enable delay
    ext_low = 1'b1;
    step(PDLY - 1);
    chk(gate_hi, 1'b1, "R10 gate_hi before delay");
    step(1);
    chk(gate_hi, 1'b0, "R10 gate_hi after delay");
    ext_low = 1'b0;
    step(PDLY);
    chk(gate_hi, 1'b1, "R10 gate_hi re-enabled");

    // R4 trip timing, R7 hold length, R8 clear through pin
    oc = 1'b1;
    step(FILT);
    chk(pull, 1'b0, "R4 pull before confirmation");
    step(1);
    chk(pull, 1'b1, "R4 pull on trip");
    chk(gate_hi, 1'b0, "R4 gate_hi off on trip");
    chk(gate_lo, 1'b0, "R4 gate_lo off on trip");
    oc = 1'b0;
    step(HOLD - 1);
    chk(pull, 1'b1, "R7 pull at end of hold");
    ext_low = 1'b1;
    step(1);
    chk(pull, 1'b0, "R7 pull released after hold");
    step(20);
    chk(gate_hi, 1'b0, "R8 gates held while pin low");
    ext_low = 1'b0;
    step(PDLY);
    chk(gate_hi, 1'b0, "R8 still latched one edge before clear");
    step(1);
    chk(gate_hi, 1'b1, "R8 cleared by pin high");

    // R6 re-arm when still tripped at expiry
    oc = 1'b1;
    step(FILT + 1);
    chk(pull, 1'b1, "R6 trip");
    step(HOLD);
    chk(pull, 1'b1, "R6 pull kept at expiry");
    oc = 1'b0;
    step(HOLD + PDLY + 4);
    chk(pull, 1'b0, "R6 pull released");
    chk(gate_lo, 1'b1, "R6 gates back");

    // R5 trip and pin-high reach the latch together
    oc = 1'b1;
    step(FILT + 1);
    oc = 1'b0;
    ext_low = 1'b1;
    step(HOLD + 2);
    chk(pull, 1'b0, "R5 waiting state");
    oc = 1'b1;
    step(FILT - PDLY);
    ext_low = 1'b0;
    step(PDLY);
    chk(pull, 1'b0, "R5 before coincidence edge");
    step(1);
    chk(pull, 1'b1, "R5 set wins over clear");
    oc = 1'b0;
    step(HOLD + PDLY + 4);
    chk(gate_hi, 1'b1, "R5 recovered");

    // R1 mid-run reset clears latch
    oc = 1'b1;
    step(FILT + 1);
    chk(pull, 1'b1, "R1 trip before reset");
    rst_n = 1'b0;
    #1;
    chk(pull, 1'b0, "R1 pull cleared by reset");
    chk(gate_hi, 1'b0, "R1 gate_hi off in reset");
    oc = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2 + PDLY + 3);
    chk(pull, 1'b0, "R1 pull after reset");
    chk(gate_hi, 1'b1, "R1 gate_hi after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule